// File: doc/BRIEF.md
# Random Arithmetic Program Executor

This block runs a short stored program of 32-bit arithmetic instructions against a nine-entry register file. Entries 0 to 3 are working registers that the program may overwrite. Entries 4 to 8 hold operands that stay fixed for the whole run. Each stored instruction carries an operation code, a destination index, a source index and a 32-bit immediate. The immediate is only used by the addition operation.

A host first streams instruction words into the program store and values into the register file, using two valid/ready channels. It then pulses `start`. The executor steps through the store from slot 0 and completes one instruction per clock. It stops at the first return word, or at the last slot if no return word comes first. When it stops it raises `done` and presents working registers 0 to 3 on `result`.

Back-pressure rules are as follows. Both load channels present `ready` high exactly while the block is idle. A word transfers on a clock edge where `valid` and `ready` are both high. While a run is in progress `ready` is low, and any `valid` the host drives is dropped without effect.

Top module: `rmath_exec`

## Requirements
- R1: Operation codes are MUL=0 (dst*src), ADD=1 (dst+src+imm), SUB=2 (dst-src), ROR=3, ROL=4, XOR=5 and RET=6. All results wrap modulo 2^32.
- R2: ROR and ROL rotate the destination by the source value modulo 32. A rotate amount of 0 leaves the destination unchanged, so a source of 32 has no effect and a source of 33 rotates by 1.
- R3: The 2-bit destination index selects registers 0 to 3. The 4-bit source index selects registers 0 to 8. A source index of 9 to 15 reads as zero.
- R4: Within one instruction the source is read before the destination is written. When source and destination are the same register, the old value is used on both sides.
- R5: The 32-bit immediate affects only ADD. The other operations ignore it.
- R6: After `start` is taken while idle, `busy` rises on the next edge and one instruction retires per clock from slot 0. On reaching a RET word, or the unused code 7, the run ends. For N working instructions, `done` is seen high N+1 clocks after the start edge. `done` holds until the next start.
- R7: Slot 70 is the final slot of the 71-word store. Whatever word it holds, execution ends there without executing it, so at most 70 instructions retire per run.
- R8: `prog_ready` and `reg_ready` are high only while idle, and words offered while busy are dropped. A program address above 70 or a register index above 8 is also dropped.
- R9: A start pulse while busy is ignored and does not restart the run.
- R10: After reset all registers read zero, and `busy` and `done` are low.
- R11: On `result`, working register k occupies bits [32k+31:32k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_valid | input | 1 | Instruction word offered |
| prog_ready | output | 1 | Program store accepts a word (idle only) |
| prog_addr | input | 7 | Store slot, 0 to 70 |
| prog_op | input | 3 | Operation code |
| prog_dst | input | 2 | Destination register index |
| prog_src | input | 4 | Source register index |
| prog_imm | input | 32 | Immediate for ADD |
| reg_valid | input | 1 | Register value offered |
| reg_ready | output | 1 | Register file accepts a value (idle only) |
| reg_idx | input | 4 | Register index, 0 to 8 |
| reg_data | input | 32 | Register value |
| start | input | 1 | Begin a run when idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run finished |
| result | output | 128 | Working registers 0 to 3 |

## Verification
Two situations are the hardest to reach: a run that reaches the store's last slot without ever seeing a return word, and traffic that arrives on every input during a run. To reach the first, the bench fills all 71 slots with counting additions, so the retire count and the run length show where execution stopped. While that long run is active, it drives a return word into an early slot, a new value into register 0 and a second start pulse. It then checks that the final count and cycle total are unchanged. A second run of the same stored program then confirms that the store kept its original contents. Randomly generated 60-to-70-instruction programs are compared against a model inside the bench.

// File: rtl/rmath_pkg.sv
package rmath_pkg;
  localparam int XLEN   = 32;
  localparam int NREG   = 9;
  localparam int NVAR   = 4;
  localparam int OPW    = 3;
  localparam int DSTW   = $clog2(NVAR);
  localparam int SRCW   = 4;
  localparam int SHW    = $clog2(XLEN);

  typedef enum logic [OPW-1:0] {
    OP_MUL = 3'd0,
    OP_ADD = 3'd1,
    OP_SUB = 3'd2,
    OP_ROR = 3'd3,
    OP_ROL = 3'd4,
    OP_XOR = 3'd5,
    OP_RET = 3'd6,
    OP_HLT = 3'd7
  } op_e;

  typedef struct packed {
    logic [OPW-1:0]  op;
    logic [DSTW-1:0] dst;
    logic [SRCW-1:0] src;
    logic [XLEN-1:0] imm;
  } instr_t;

  localparam int IW = $bits(instr_t);
endpackage

// File: rtl/rmath_alu.sv
module rmath_alu
  import rmath_pkg::*;
(
  input  logic [OPW-1:0]  op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [XLEN-1:0] imm,
  output logic [XLEN-1:0] y
);
  logic [SHW-1:0]    amt;
  logic [2*XLEN-1:0] dbl;
  logic [2*XLEN-1:0] rr;
  logic [2*XLEN-1:0] rl;
  logic [XLEN-1:0]   prod;

  assign amt  = b[SHW-1:0];           // R2 modulo register width
  assign dbl  = {a, a};
  assign rr   = dbl >> amt;
  assign rl   = dbl << amt;
  assign prod = a * b;

  always_comb begin
    unique case (op)
      OP_MUL:  y = prod;
      OP_ADD:  y = a + b + imm;       // R5 only user of imm
      OP_SUB:  y = a - b;
      OP_ROR:  y = rr[XLEN-1:0];
      OP_ROL:  y = rl[2*XLEN-1:XLEN];
      OP_XOR:  y = a ^ b;
      default: y = a;
    endcase
  end
endmodule

// File: rtl/rmath_regs.sv
module rmath_regs
  import rmath_pkg::*;
#(
  parameter int N  = NREG,
  parameter int NV = NVAR,
  parameter int W  = XLEN,
  parameter int IXW = SRCW,
  parameter int DW = DSTW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_we,
  input  logic [IXW-1:0]  host_idx,
  input  logic [W-1:0]    host_data,
  input  logic            exe_we,
  input  logic [DW-1:0]   exe_idx,
  input  logic [W-1:0]    exe_data,
  input  logic [IXW-1:0]  src_idx,
  output logic [W-1:0]    src_data,
  input  logic [DW-1:0]   dst_idx,
  output logic [W-1:0]    dst_data,
  output logic [NV*W-1:0] var_out
);
  logic [W-1:0] r [N];

  for (genvar k = 0; k < N; k++) begin : g_reg
    if (k < NV) begin : g_var
      always_ff @(posedge clk) begin
        if (!rst_n)                                   r[k] <= '0;
        else if (exe_we && exe_idx == DW'(k))         r[k] <= exe_data;
        else if (host_we && host_idx == IXW'(k))      r[k] <= host_data;
      end
      assign var_out[k*W +: W] = r[k];
    end else begin : g_const
      always_ff @(posedge clk) begin
        if (!rst_n)                                   r[k] <= '0;
        else if (host_we && host_idx == IXW'(k))      r[k] <= host_data;
      end
    end
  end

  always_comb begin
    src_data = '0;                    // R3 out-of-range source reads zero
    for (int k = 0; k < N; k++)
      if (src_idx == IXW'(k)) src_data = r[k];
  end

  always_comb begin
    dst_data = '0;
    for (int k = 0; k < NV; k++)
      if (dst_idx == DW'(k)) dst_data = r[k];
  end
endmodule

// File: rtl/rmath_pmem.sv
module rmath_pmem
  import rmath_pkg::*;
#(
  parameter int DEPTH = 71,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  instr_t        wdata,
  input  logic [AW-1:0] raddr,
  output instr_t        rdata
);
  instr_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (int'(waddr) < DEPTH)) mem[waddr] <= wdata;   // R8 drop high slots
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rmath_ctrl.sv
module rmath_ctrl
  import rmath_pkg::*;
#(
  parameter int DEPTH = 71,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [OPW-1:0] cur_op,
  output logic [AW-1:0]  pc,
  output logic           busy,
  output logic           done,
  output logic           exe_we
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic stop;

  assign stop   = (cur_op == OP_RET) || (cur_op == OP_HLT) || (pc == LAST);  // R6 R7
  assign exe_we = busy && !stop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      pc   <= '0;
    end else if (!busy) begin
      if (start) begin               // R9 start only sampled while idle
        busy <= 1'b1;
        done <= 1'b0;
        pc   <= '0;
      end
    end else if (stop) begin
      busy <= 1'b0;
      done <= 1'b1;
    end else begin
      pc <= pc + 1'b1;
    end
  end
endmodule

// File: rtl/rmath_exec.sv
module rmath_exec
  import rmath_pkg::*;
#(
  parameter int PROG_DEPTH = 71,
  localparam int AW = $clog2(PROG_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_valid,
  output logic              prog_ready,
  input  logic [AW-1:0]     prog_addr,
  input  logic [OPW-1:0]    prog_op,
  input  logic [DSTW-1:0]   prog_dst,
  input  logic [SRCW-1:0]   prog_src,
  input  logic [XLEN-1:0]   prog_imm,
  input  logic              reg_valid,
  output logic              reg_ready,
  input  logic [SRCW-1:0]   reg_idx,
  input  logic [XLEN-1:0]   reg_data,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [NVAR*XLEN-1:0] result
);
  logic [AW-1:0]   pc;
  logic            exe_we;
  instr_t          cur;
  instr_t          wword;
  logic [XLEN-1:0] src_val;
  logic [XLEN-1:0] dst_val;
  logic [XLEN-1:0] alu_y;

  assign prog_ready = !busy;         // R8
  assign reg_ready  = !busy;
  assign wword      = '{op: prog_op, dst: prog_dst, src: prog_src, imm: prog_imm};

  rmath_ctrl #(.DEPTH(PROG_DEPTH), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cur_op(cur.op),
    .pc(pc), .busy(busy), .done(done), .exe_we(exe_we)
  );

  rmath_pmem #(.DEPTH(PROG_DEPTH), .AW(AW)) u_pmem (
    .clk(clk), .we(prog_valid && prog_ready), .waddr(prog_addr),
    .wdata(wword), .raddr(pc), .rdata(cur)
  );

  rmath_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .host_we(reg_valid && reg_ready), .host_idx(reg_idx), .host_data(reg_data),
    .exe_we(exe_we), .exe_idx(cur.dst), .exe_data(alu_y),
    .src_idx(cur.src), .src_data(src_val),
    .dst_idx(cur.dst), .dst_data(dst_val),
    .var_out(result)
  );

  rmath_alu u_alu (
    .op(cur.op), .a(dst_val), .b(src_val), .imm(cur.imm), .y(alu_y)  // R4 old values
  );
endmodule

// File: rtl/rmath_chk.sv
module rmath_chk #(
  parameter int PROG_DEPTH = 71
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         reg_valid,
  input logic         reg_ready,
  input logic [127:0] result
);
  logic [15:0] run_len;

  always_ff @(posedge clk) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 16'd1;
    else           run_len <= '0;
  end

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);                                                        // R6
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done));                                  // R6
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);                                             // R6
  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= 16'(PROG_DEPTH));                                            // R7
  AST_BUSY_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));                                          // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(reg_valid && reg_ready)) |=> $stable(result));              // R8
endmodule

bind rmath_exec rmath_chk #(.PROG_DEPTH(PROG_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .reg_valid(reg_valid), .reg_ready(reg_ready), .result(result)
);

// File: tb/sim_rmath_exec.sv
module sim_rmath_exec;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         prog_valid = 1'b0;
  logic         prog_ready;
  logic [6:0]   prog_addr = '0;
  logic [2:0]   prog_op = '0;
  logic [1:0]   prog_dst = '0;
  logic [3:0]   prog_src = '0;
  logic [31:0]  prog_imm = '0;
  logic         reg_valid = 1'b0;
  logic         reg_ready;
  logic [3:0]   reg_idx = '0;
  logic [31:0]  reg_data = '0;
  logic         start = 1'b0;
  logic         busy;
  logic         done;
  logic [127:0] result;

  int nchk = 0;
  int nerr = 0;

  always #5 clk = ~clk;

  rmath_exec u0 (
    .clk(clk), .rst_n(rst_n), .prog_valid(prog_valid), .prog_ready(prog_ready),
    .prog_addr(prog_addr), .prog_op(prog_op), .prog_dst(prog_dst),
    .prog_src(prog_src), .prog_imm(prog_imm), .reg_valid(reg_valid),
    .reg_ready(reg_ready), .reg_idx(reg_idx), .reg_data(reg_data),
    .start(start), .busy(busy), .done(done), .result(result)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  dst;
    logic [3:0]  src;
    logic [31:0] imm;
    logic [31:0] exp;
  } vec_t;

  localparam logic [31:0] INIT [9] = '{32'h3, 32'h80000001, 32'h0000FFFF, 32'hFFFFFFFF,
                                       32'h4, 32'h20, 32'h21, 32'h12345678, 32'h0};

  localparam vec_t VEC [15] = '{
    '{3'd0, 2'd0, 4'd2, 32'h0,     32'h0002FFFD},  // R1 mul
    '{3'd0, 2'd3, 4'd3, 32'h0,     32'h00000001},  // R4 mul self wraps
    '{3'd1, 2'd0, 4'd1, 32'h5,     32'h80000009},  // R1 add with imm
    '{3'd1, 2'd3, 4'd0, 32'h0,     32'h00000002},  // R1 add wraps
    '{3'd1, 2'd1, 4'd1, 32'h10,    32'h00000012},  // R4 add self
    '{3'd2, 2'd0, 4'd1, 32'h0,     32'h80000002},  // R1 sub borrow
    '{3'd2, 2'd2, 4'd2, 32'h0,     32'h00000000},  // R4 sub self
    '{3'd3, 2'd1, 4'd4, 32'h0,     32'h18000000},  // R2 ror 4
    '{3'd4, 2'd1, 4'd4, 32'h0,     32'h00000018},  // R2 rol 4
    '{3'd3, 2'd2, 4'd5, 32'h0,     32'h0000FFFF},  // R2 ror 32 = 0
    '{3'd4, 2'd2, 4'd6, 32'h0,     32'h0001FFFE},  // R2 rol 33 = 1
    '{3'd5, 2'd3, 4'd7, 32'h0,     32'hEDCBA987},  // R1 xor
    '{3'd5, 2'd0, 4'd12, 32'h0,    32'h00000003},  // R3 src 12 reads zero
    '{3'd2, 2'd0, 4'd7, 32'hFFFF,  32'hEDCBA98B},  // R5 imm ignored by sub
    '{3'd0, 2'd2, 4'd8, 32'h7,     32'h00000000}   // R5 imm ignored by mul
  };

  logic [2:0]  m_op  [71];
  logic [1:0]  m_dst [71];
  logic [3:0]  m_src [71];
  logic [31:0] m_imm [71];
  logic [31:0] mr    [9];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_instr(input int a, input logic [2:0] op, input logic [1:0] d,
                           input logic [3:0] s, input logic [31:0] c);
    @(negedge clk);
    prog_valid = 1'b1; prog_addr = 7'(a); prog_op = op;
    prog_dst = d; prog_src = s; prog_imm = c;
    @(negedge clk);
    prog_valid = 1'b0;
  endtask

  task automatic put_reg(input int i, input logic [31:0] v);
    @(negedge clk);
    reg_valid = 1'b1; reg_idx = 4'(i); reg_data = v;
    @(negedge clk);
    reg_valid = 1'b0;
  endtask

  task automatic put_init();
    for (int k = 0; k < 9; k++) put_reg(k, INIT[k]);
  endtask

  task automatic run(output int cyc);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  function automatic logic [31:0] model_op(input logic [2:0] op, input logic [31:0] d,
                                           input logic [31:0] s, input logic [31:0] c);
    logic [63:0] w;
    logic [4:0]  n;
    n = s[4:0];
    w = {d, d};
    case (op)
      3'd0: return d * s;
      3'd1: return d + s + c;
      3'd2: return d - s;
      3'd3: begin w = w >> n; return w[31:0]; end
      3'd4: begin w = w << n; return w[63:32]; end
      3'd5: return d ^ s;
      default: return d;
    endcase
  endfunction

  initial begin
    #2_000_000;
    nerr++;
    $display("FAIL R6 watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 result", result[31:0] | result[63:32] | result[95:64] | result[127:96], 32'h0);
    chk("R10 busy/done", {30'd0, busy, done}, 32'h0);
    chk("R8 ready idle", {30'd0, prog_ready, reg_ready}, 32'h3);

    // Table walk: single instruction then RET
    for (int v = 0; v < 15; v++) begin
      put_init();
      put_instr(0, VEC[v].op, VEC[v].dst, VEC[v].src, VEC[v].imm);
      put_instr(1, 3'd6, 2'd0, 4'd0, 32'h0);
      run(cyc);
      chk("R6 one-instr length", 32'(cyc), 32'd2);
      for (int k = 0; k < 4; k++)
        chk($sformatf("R1 vec%0d r%0d (R11 lane)", v, k), result[k*32 +: 32],
            (k == int'(VEC[v].dst)) ? VEC[v].exp : INIT[k]);
    end

    // R6 empty program: RET in slot 0
    put_init();
    put_instr(0, 3'd6, 2'd0, 4'd0, 32'h0);
    run(cyc);
    chk("R6 empty length", 32'(cyc), 32'd1);
    chk("R6 empty r0", result[31:0], INIT[0]);

    // R6 code 7 also halts
    put_init();
    put_instr(0, 3'd1, 2'd0, 4'd8, 32'd5);
    put_instr(1, 3'd7, 2'd0, 4'd0, 32'h0);
    put_instr(2, 3'd1, 2'd0, 4'd8, 32'd100);
    put_instr(3, 3'd6, 2'd0, 4'd0, 32'h0);
    run(cyc);
    chk("R6 code7 length", 32'(cyc), 32'd2);
    chk("R6 code7 r0", result[31:0], 32'd8);

    // R3 R8 out-of-range register and slot writes dropped
    put_init();
    put_reg(9, 32'h55);
    put_instr(0, 3'd5, 2'd1, 4'd9, 32'h0);
    put_instr(1, 3'd6, 2'd0, 4'd0, 32'h0);
    put_instr(100, 3'd1, 2'd1, 4'd8, 32'h1);
    run(cyc);
    chk("R3 src9 zero", result[63:32], INIT[1]);

    // Random programs against bench model
    for (int p = 0; p < 8; p++) begin
      int n;
      n = $urandom_range(60, 70);
      for (int k = 0; k < 9; k++) begin
        mr[k] = $urandom;
        put_reg(k, mr[k]);
      end
      for (int i = 0; i < n; i++) begin
        m_op[i] = 3'($urandom_range(0, 5));
        m_dst[i] = 2'($urandom_range(0, 3));
        m_src[i] = 4'($urandom_range(0, 8));
        m_imm[i] = $urandom;
        put_instr(i, m_op[i], m_dst[i], m_src[i], m_imm[i]);
      end
      if (n < 71) put_instr(n, 3'd6, 2'd0, 4'd0, 32'h0);
      for (int i = 0; i < n; i++)
        mr[m_dst[i]] = model_op(m_op[i], mr[m_dst[i]], mr[m_src[i]], m_imm[i]);
      run(cyc);
      chk($sformatf("R6 prog%0d length", p), 32'(cyc), 32'(n + 1));
      for (int k = 0; k < 4; k++)
        chk($sformatf("R1 prog%0d r%0d", p, k), result[k*32 +: 32], mr[k]);
    end

    // R7 every slot is a counting add; slot 70 must not execute
    put_init();
    for (int i = 0; i < 71; i++) put_instr(i, 3'd1, 2'd0, 4'd8, 32'd1);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b1;                      // R9 second start while busy
    prog_valid = 1'b1; prog_addr = 7'd5; prog_op = 3'd6;
    prog_dst = 2'd0; prog_src = 4'd0; prog_imm = 32'h0;
    reg_valid = 1'b1; reg_idx = 4'd0; reg_data = 32'hDEAD;
    chk("R8 ready low busy", {30'd0, prog_ready, reg_ready}, 32'h0);
    cyc = 0;
    @(negedge clk);
    cyc++;
    start = 1'b0; prog_valid = 1'b0; reg_valid = 1'b0;
    while (!done && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
    chk("R7 R9 budget length", 32'(cyc), 32'd71);
    chk("R7 R8 r0 count", result[31:0], 32'd73);
    repeat (5) @(negedge clk);
    chk("R6 done holds", {31'd0, done}, 32'd1);
    run(cyc);
    chk("R8 store kept length", 32'(cyc), 32'd71);
    chk("R8 store kept r0", result[31:0], 32'd143);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule